// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller with Shadow Words

This block manages a small array of one-time-programmable fuse words on behalf of software. Software never touches a fuse directly: every fuse word has a 32-bit shadow register that the bus can read and write. A command register starts one of two operations on a chosen word. A reload copies the fuse word into its shadow. A program burns bits from a staged write-data value into the fuse word. Each operation keeps a busy flag up for a fixed number of cycles, and software polls that flag.

The fuse array must be powered before it is used. A configuration bit requests power, and a status bit reports the array as powered once a settling delay has passed, in both directions. Sticky per-word lock bitmaps restrict what software may do. A read lock makes a reload load zero. A write lock makes bus writes to that shadow do nothing. A program lock, or one global program lock, leaves the fuse word untouched. Per-word error and disturbed bitmaps record rejected commands and shadows that have become stale. A debug-enable flag is held in a register and driven on a pin.

The fuse array is modelled with flip-flops, and the length of an operation is a parameter. Register map, byte offsets: configuration 0x000, command 0x004, write data 0x008, status 0x00C, global lock 0x010, debug 0x014. The bitmaps start at disturbed 0x020, error 0x040, read lock 0x060, write lock 0x080 and program lock 0x0A0. Shadow word n sits at 0x200 + 4×n.

Top module: `otp_shadow_ctrl`

## Requirements
- R1: After reset the status register, every shadow word, every bitmap, the global lock and the debug flag read as zero.
- R2: Configuration bit 0 is the power request. Status bit 5 (powered) takes the new request value PWR_DLY cycles after the write edge, both when powering up and when powering down.
- R3: Writing the command register with bit 8 = 0 and a word index in bits [6:0] starts a reload. Status bit 3 (busy) is high for OP_LAT cycles after the write edge. When busy drops, the shadow of that word holds the fuse value.
- R4: Writing the command register with bit 8 = 1 starts a program. At completion the fuse word becomes its old value OR the write-data register, and fuse bits never clear. The shadow word is not changed by a program.
- R5: Status bit 4 (program fail) is set at the end of a program if any bit of the write data is still 0 in the fuse word. Every accepted command clears it when the command starts.
- R6: A reload of a word whose read-lock bit is set loads zero into that shadow.
- R7: A bus write to shadow word n stores the data unless the word's write-lock bit is set. If that bit is set, the write has no effect.
- R8: A program leaves the fuse word unchanged when the word's program-lock bit is set or when bit 4 of the global lock register is set.
- R9: A command issued while the array is unpowered, or while busy is high, is rejected. It starts no operation, leaves the fuses unchanged and sets the word's error bit. An accepted command on that word clears the error bit.
- R10: Each bitmap keeps word n in the register at bitmap base + 4×(n>>5), bit n[4:0]. Lock bits and the global lock can only be set by writing 1. Writing 0 leaves them set, and only reset clears them.
- R11: A completed program sets the word's disturbed bit. A completed reload of that word clears it.
- R12: Bit 10 of the debug register is a read/write flag, and its value drives the dbg_sw_en output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, same cycle |
| dbg_sw_en | output | 1 | Software debug enable flag |

## Verification
Reads are combinational, so a value read reflects every write edge before it. A register write or a command takes effect at the clock edge that samples it. Busy is visible from that edge for exactly OP_LAT cycles, and the shadow, fuse, fail, error and disturbed results appear at edge + OP_LAT. The powered bit changes at edge + PWR_DLY. The bench drives and samples on falling edges and checks busy one cycle before and at the completion edge, and powered one cycle before and at the settling edge, so results that come early or late are both caught.

// File: rtl/otp_pkg.sv
// Shared register map, bit positions and operation type of the fuse controller.
// Assumes byte addressing on a 12-bit bus with 32-bit registers.
package otp_pkg;
    localparam int unsigned DW = 32;

    localparam logic [11:0] A_CFG    = 12'h000;
    localparam logic [11:0] A_CMD    = 12'h004;
    localparam logic [11:0] A_WDATA  = 12'h008;
    localparam logic [11:0] A_STAT   = 12'h00C;
    localparam logic [11:0] A_GLOCK  = 12'h010;
    localparam logic [11:0] A_DBG    = 12'h014;
    localparam logic [11:0] A_DIST   = 12'h020;
    localparam logic [11:0] A_ERR    = 12'h040;
    localparam logic [11:0] A_RDLK   = 12'h060;
    localparam logic [11:0] A_WRLK   = 12'h080;
    localparam logic [11:0] A_PGLK   = 12'h0A0;
    localparam logic [11:0] A_SHADOW = 12'h200;

    localparam int BIT_BUSY  = 3;
    localparam int BIT_FAIL  = 4;
    localparam int BIT_PWR   = 5;
    localparam int BIT_OP    = 8;
    localparam int BIT_GLOCK = 4;
    localparam int BIT_DBG   = 10;

    typedef enum logic {
        OP_RELOAD  = 1'b0,
        OP_PROGRAM = 1'b1
    } otp_op_e;
endpackage

// File: rtl/otp_power_seq.sv
// Power settling model: powered follows req after PWR_DLY cycles of disagreement.
// Assumes PWR_DLY >= 1; a request that returns to the current state aborts the count.
module otp_power_seq #(
    parameter int unsigned PWR_DLY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic powered
);
    localparam int unsigned CW = $clog2(PWR_DLY + 1);

    logic [CW-1:0] cnt;

    // Count cycles while request and state differ, then adopt the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            powered <= 1'b0;
        end else if (req == powered) begin
            cnt <= '0;
        end else if (cnt == CW'(PWR_DLY - 1)) begin
            powered <= req;
            cnt     <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/otp_bitmap.sv
// Per-word flag vector with set and clear masks; set wins over clear.
// Assumes masks are single-cycle strobes from the register decoder.
module otp_bitmap #(
    parameter int unsigned N = 96
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_mask,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] bits
);
    // Apply clear then set each cycle; reset empties the map.
    always_ff @(posedge clk) begin
        if (!rst_n) bits <= '0;
        else        bits <= (bits & ~clr_mask) | set_mask;
    end
endmodule

// File: rtl/otp_fuse_core.sv
// Fuse word storage plus the single-operation sequencer (reload / program).
// Assumes start only when idle and start_idx < NUM_WORDS; OP_LAT >= 1.
module otp_fuse_core
    import otp_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 96,
    parameter int unsigned OP_LAT    = 8,
    parameter int unsigned IW        = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  otp_op_e                 start_op,
    input  logic [IW-1:0]           start_idx,
    input  logic [DW-1:0]           start_wdata,
    input  logic [NUM_WORDS-1:0]    rd_lock,
    input  logic [NUM_WORDS-1:0]    pg_lock,
    input  logic                    glock,
    output logic                    busy,
    output logic                    prog_fail,
    output logic                    done,
    output otp_op_e                 done_op,
    output logic [IW-1:0]           done_idx,
    output logic [DW-1:0]           done_data,
    output logic [NUM_WORDS*DW-1:0] fuse_flat
);
    localparam int unsigned CW = $clog2(OP_LAT + 1);

    logic [CW-1:0] cnt;
    otp_op_e       op_q;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] wd_q;
    logic [DW-1:0] fuse [NUM_WORDS];
    logic [DW-1:0] cur;
    logic [DW-1:0] prog_val;
    logic          blocked;

    assign done      = busy && (cnt == CW'(OP_LAT - 1));
    assign cur       = fuse[idx_q];
    assign blocked   = pg_lock[idx_q] | glock;
    assign prog_val  = blocked ? cur : (cur | wd_q);
    assign done_data = rd_lock[idx_q] ? '0 : cur;
    assign done_op   = op_q;
    assign done_idx  = idx_q;

    // Sequence one operation: latch on start, count, report fail on program end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cnt       <= '0;
            prog_fail <= 1'b0;
            op_q      <= OP_RELOAD;
            idx_q     <= '0;
            wd_q      <= '0;
        end else if (start) begin
            busy      <= 1'b1;
            cnt       <= '0;
            prog_fail <= 1'b0;
            op_q      <= start_op;
            idx_q     <= start_idx;
            wd_q      <= start_wdata;
        end else if (done) begin
            busy <= 1'b0;
            if (op_q == OP_PROGRAM)
                prog_fail <= (prog_val & wd_q) != wd_q;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
        end
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_fuse
        // Burn the selected fuse word when a program completes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                fuse[w] <= '0;
            else if (done && op_q == OP_PROGRAM && idx_q == IW'(w))
                fuse[w] <= prog_val;
        end
        assign fuse_flat[w*DW +: DW] = fuse[w];
    end
endmodule

// File: rtl/otp_shadow_ctrl.sv
// Top: register decode, shadow words, lock/status bitmaps and read mux.
// Assumes NUM_WORDS <= 256 so bitmaps fit eight banks and shadows fit the map.
module otp_shadow_ctrl
    import otp_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 96,
    parameter int unsigned OP_LAT    = 8,
    parameter int unsigned PWR_DLY   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        dbg_sw_en
);
    localparam int unsigned IW   = $clog2(NUM_WORDS);
    localparam int unsigned NB   = (NUM_WORDS + 31) / 32;
    localparam int unsigned PADW = NB * 32;

    logic                    wr_en, pwr_req, glock, dbg_en, powered, busy, prog_fail;
    logic [DW-1:0]           wdata_q;
    logic                    cmd_wr, cmd_ok, accept, reject;
    logic [IW-1:0]           cmd_idx;
    logic                    done;
    otp_op_e                 done_op;
    logic [IW-1:0]           done_idx;
    logic [DW-1:0]           done_data;
    logic [NUM_WORDS*DW-1:0] fuse_flat;
    logic [11:0]             sh_off;
    logic [9:0]              sh_word;
    logic                    sh_hit;
    logic [DW-1:0]           shadow [NUM_WORDS];
    logic [NUM_WORDS-1:0]    rd_lock, wr_lock, pg_lock, err_bits, dist_bits;
    logic [NUM_WORDS-1:0]    rdlk_set, wrlk_set, pglk_set, err_set, err_clr, dist_set, dist_clr;
    logic [PADW-1:0]         dist_pad, err_pad, rdlk_pad, wrlk_pad, pglk_pad;

    assign wr_en     = bus_sel & bus_we;
    assign dbg_sw_en = dbg_en;

    // Hold configuration, staged program data, global lock and debug flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_req <= 1'b0;
            wdata_q <= '0;
            glock   <= 1'b0;
            dbg_en  <= 1'b0;
        end else if (wr_en) begin
            case (bus_addr)
                A_CFG:   pwr_req <= bus_wdata[0];
                A_WDATA: wdata_q <= bus_wdata;
                A_GLOCK: if (bus_wdata[BIT_GLOCK]) glock <= 1'b1;
                A_DBG:   dbg_en  <= bus_wdata[BIT_DBG];
                default: ;
            endcase
        end
    end

    assign cmd_wr  = wr_en && (bus_addr == A_CMD);
    assign cmd_idx = bus_wdata[IW-1:0];
    assign cmd_ok  = 32'(cmd_idx) < NUM_WORDS;
    assign accept  = cmd_wr && cmd_ok && powered && !busy;
    assign reject  = cmd_wr && cmd_ok && !accept;

    assign sh_off  = bus_addr - A_SHADOW;
    assign sh_word = sh_off[11:2];
    assign sh_hit  = (bus_addr >= A_SHADOW) && (sh_off[1:0] == 2'b00) && (32'(sh_word) < NUM_WORDS);

    otp_power_seq #(.PWR_DLY(PWR_DLY)) u_pwr (
        .clk(clk), .rst_n(rst_n), .req(pwr_req), .powered(powered)
    );

    otp_fuse_core #(.NUM_WORDS(NUM_WORDS), .OP_LAT(OP_LAT), .IW(IW)) u_core (
        .clk(clk), .rst_n(rst_n), .start(accept),
        .start_op(otp_op_e'(bus_wdata[BIT_OP])), .start_idx(cmd_idx), .start_wdata(wdata_q),
        .rd_lock(rd_lock), .pg_lock(pg_lock), .glock(glock),
        .busy(busy), .prog_fail(prog_fail), .done(done), .done_op(done_op),
        .done_idx(done_idx), .done_data(done_data), .fuse_flat(fuse_flat)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam int BK = w / 32;
        localparam int BT = w % 32;
        assign rdlk_set[w] = wr_en && (bus_addr == A_RDLK + 12'(4 * BK)) && bus_wdata[BT];
        assign wrlk_set[w] = wr_en && (bus_addr == A_WRLK + 12'(4 * BK)) && bus_wdata[BT];
        assign pglk_set[w] = wr_en && (bus_addr == A_PGLK + 12'(4 * BK)) && bus_wdata[BT];
        assign err_set[w]  = reject && (cmd_idx == IW'(w));
        assign err_clr[w]  = accept && (cmd_idx == IW'(w));
        assign dist_set[w] = done && (done_op == OP_PROGRAM) && (done_idx == IW'(w));
        assign dist_clr[w] = done && (done_op == OP_RELOAD) && (done_idx == IW'(w));

        // Update one shadow word from a finished reload or an unlocked bus write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow[w] <= '0;
            else if (dist_clr[w])
                shadow[w] <= done_data;
            else if (wr_en && sh_hit && (sh_word == 10'(w)) && !wr_lock[w])
                shadow[w] <= bus_wdata;
        end
    end

    otp_bitmap #(.N(NUM_WORDS)) u_rdlk (.clk(clk), .rst_n(rst_n), .set_mask(rdlk_set), .clr_mask('0), .bits(rd_lock));
    otp_bitmap #(.N(NUM_WORDS)) u_wrlk (.clk(clk), .rst_n(rst_n), .set_mask(wrlk_set), .clr_mask('0), .bits(wr_lock));
    otp_bitmap #(.N(NUM_WORDS)) u_pglk (.clk(clk), .rst_n(rst_n), .set_mask(pglk_set), .clr_mask('0), .bits(pg_lock));
    otp_bitmap #(.N(NUM_WORDS)) u_err  (.clk(clk), .rst_n(rst_n), .set_mask(err_set),  .clr_mask(err_clr),  .bits(err_bits));
    otp_bitmap #(.N(NUM_WORDS)) u_dist (.clk(clk), .rst_n(rst_n), .set_mask(dist_set), .clr_mask(dist_clr), .bits(dist_bits));

    assign dist_pad = PADW'(dist_bits);
    assign err_pad  = PADW'(err_bits);
    assign rdlk_pad = PADW'(rd_lock);
    assign wrlk_pad = PADW'(wr_lock);
    assign pglk_pad = PADW'(pg_lock);

    // Select read data for the addressed register, bitmap bank or shadow word.
    always_comb begin
        bus_rdata = '0;
        if (sh_hit) begin
            bus_rdata = shadow[sh_word[IW-1:0]];
        end else begin
            case (bus_addr)
                A_CFG:   bus_rdata[0] = pwr_req;
                A_WDATA: bus_rdata = wdata_q;
                A_STAT: begin
                    bus_rdata[BIT_BUSY] = busy;
                    bus_rdata[BIT_FAIL] = prog_fail;
                    bus_rdata[BIT_PWR]  = powered;
                end
                A_GLOCK: bus_rdata[BIT_GLOCK] = glock;
                A_DBG:   bus_rdata[BIT_DBG]   = dbg_en;
                default: begin
                    for (int b = 0; b < NB; b++) begin
                        if (bus_addr == A_DIST + 12'(4 * b)) bus_rdata = dist_pad[b*32 +: 32];
                        if (bus_addr == A_ERR  + 12'(4 * b)) bus_rdata = err_pad[b*32 +: 32];
                        if (bus_addr == A_RDLK + 12'(4 * b)) bus_rdata = rdlk_pad[b*32 +: 32];
                        if (bus_addr == A_WRLK + 12'(4 * b)) bus_rdata = wrlk_pad[b*32 +: 32];
                        if (bus_addr == A_PGLK + 12'(4 * b)) bus_rdata = pglk_pad[b*32 +: 32];
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/otp_shadow_ctrl_chk.sv
// Property checker for the fuse controller, bound into the top module.
// Assumes the signal names of otp_shadow_ctrl.
module otp_shadow_ctrl_chk #(
    parameter int unsigned NUM_WORDS = 96
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    busy,
    input logic                    powered,
    input logic                    pwr_req,
    input logic                    prog_fail,
    input logic [NUM_WORDS*32-1:0] fuse_flat,
    input logic [NUM_WORDS-1:0]    rd_lock,
    input logic [NUM_WORDS-1:0]    wr_lock,
    input logic [NUM_WORDS-1:0]    pg_lock
);
    AST_PWR_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(powered) |-> (powered == $past(pwr_req))); // R2

    AST_START_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(powered)); // R9

    AST_FUSE_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(fuse_flat) & ~fuse_flat) == '0)); // R4

    AST_FAIL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_fail) |-> $fell(busy)); // R5

    AST_LOCKS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(rd_lock) & ~rd_lock) | ($past(wr_lock) & ~wr_lock) | ($past(pg_lock) & ~pg_lock)) == '0)); // R10
endmodule

bind otp_shadow_ctrl otp_shadow_ctrl_chk #(.NUM_WORDS(NUM_WORDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .powered(powered), .pwr_req(pwr_req),
    .prog_fail(prog_fail), .fuse_flat(fuse_flat), .rd_lock(rd_lock),
    .wr_lock(wr_lock), .pg_lock(pg_lock)
);

// File: tb/otp_shadow_ctrl_tb.sv
module otp_shadow_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NW  = 96;
    localparam int OPL = 4;
    localparam int PWD = 6;

    localparam logic [11:0] CFG = 12'h000, CMD = 12'h004, WDAT = 12'h008, STAT = 12'h00C;
    localparam logic [11:0] GLK = 12'h010, DBG = 12'h014, DIST = 12'h020, ERR = 12'h040;
    localparam logic [11:0] RDLK = 12'h060, WRLK = 12'h080, PGLK = 12'h0A0, SHB = 12'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_sw_en;

    int n_tests = 0, n_fail = 0;
    bit finished = 1'b0;

    bit [31:0] fuse_m [NW];
    bit [31:0] shadow_m [NW];
    bit        rdl [NW], wrl [NW], pgl [NW];
    bit        glk_m = 1'b0;

    otp_shadow_ctrl #(.NUM_WORDS(NW), .OP_LAT(OPL), .PWR_DLY(PWD)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_sw_en(dbg_sw_en)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [11:0] bank_addr(input logic [11:0] base, input int w);
        return base + 12'(4 * (w >> 5));
    endfunction

    function automatic logic [31:0] bank_bit(input int w);
        return 32'h1 << (w & 31);
    endfunction

    function automatic logic [31:0] exp_reload(input int w);
        return rdl[w] ? 32'h0 : fuse_m[w];
    endfunction

    // Busy high through edge+OPL-1, low from edge+OPL (R3)
    task automatic wait_op(input string tag);
        logic [31:0] s;
        bus_read(STAT, s); check({tag, " busy at start"}, 32'(s[3]), 1);
        repeat (OPL - 1) @(negedge clk);
        bus_read(STAT, s); check({tag, " busy before end"}, 32'(s[3]), 1);
        @(negedge clk);
        bus_read(STAT, s); check({tag, " busy cleared"}, 32'(s[3]), 0);
    endtask

    task automatic do_reload(input int w);
        bus_write(CMD, 32'(w));
        wait_op("R3");
        shadow_m[w] = exp_reload(w);
    endtask

    task automatic do_program(input int w, input logic [31:0] d);
        logic [31:0] s;
        bit          exp_fail;
        bus_write(WDAT, d);
        bus_write(CMD, 32'h100 | 32'(w));
        wait_op("R4");
        if (!(pgl[w] || glk_m)) fuse_m[w] = fuse_m[w] | d;
        exp_fail = (fuse_m[w] & d) != d;
        bus_read(STAT, s);
        check("R5 fail flag", 32'(s[4]), 32'(exp_fail));
    endtask

    task automatic shadow_write(input int w, input logic [31:0] d);
        bus_write(SHB + 12'(4 * w), d);
        if (!wrl[w]) shadow_m[w] = d;
    endtask

    task automatic set_lock(input logic [11:0] base, input int w);
        bus_write(bank_addr(base, w), bank_bit(w));
        if (base == RDLK) rdl[w] = 1'b1;
        if (base == WRLK) wrl[w] = 1'b1;
        if (base == PGLK) pgl[w] = 1'b1;
    endtask

    task automatic check_shadow(input string tag, input int w);
        logic [31:0] d;
        bus_read(SHB + 12'(4 * w), d);
        check(tag, d, shadow_m[w]);
    endtask

    task automatic check_bit(input string tag, input logic [11:0] base, input int w, input bit exp);
        logic [31:0] d;
        bus_read(bank_addr(base, w), d);
        check(tag, 32'((d & bank_bit(w)) != 0), 32'(exp));
    endtask

    task automatic power(input bit on);
        logic [31:0] s;
        bus_write(CFG, 32'(on));
        repeat (PWD - 1) @(negedge clk);
        bus_read(STAT, s); check("R2 powered before delay", 32'(s[5]), 32'(!on));
        @(negedge clk);
        bus_read(STAT, s); check("R2 powered after delay", 32'(s[5]), 32'(on));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0F75);
        for (int i = 0; i < NW; i++) begin
            fuse_m[i] = '0; shadow_m[i] = '0; rdl[i] = 0; wrl[i] = 0; pgl[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(STAT, d);  check("R1 status", d, 0);
        check_shadow("R1 shadow", 5);
        bus_read(RDLK + 12'h8, d); check("R1 lock bank", d, 0);
        bus_read(GLK, d);   check("R1 global lock", d, 0);
        check("R1 debug pin", 32'(dbg_sw_en), 0);

        // R9 reject while unpowered
        bus_write(CMD, 32'd7);
        bus_read(STAT, d); check("R9 no busy unpowered", 32'(d[3]), 0);
        check_bit("R9 error set unpowered", ERR, 7, 1);

        power(1'b1);

        // R4 / R11 program then reload
        do_program(3, 32'h0000_00A5);
        check_shadow("R4 shadow untouched by program", 3);
        check_bit("R11 disturbed set", DIST, 3, 1);
        do_reload(3);
        check_shadow("R3 reload value", 3);
        check_bit("R11 disturbed cleared", DIST, 3, 0);
        do_program(3, 32'h0000_005A);
        do_reload(3);
        check_shadow("R4 OR accumulate", 3);

        // R9 error cleared by accepted op
        do_reload(7);
        check_bit("R9 error cleared", ERR, 7, 0);

        // R9 reject while busy
        bus_write(CMD, 32'd10);
        bus_write(CMD, 32'd11);
        repeat (OPL) @(negedge clk);
        shadow_m[10] = exp_reload(10);
        check_bit("R9 error set busy", ERR, 11, 1);
        check_shadow("R3 reload during reject", 10);

        // R8 / R5 per-word program lock
        set_lock(PGLK, 40);
        check_bit("R10 bank1 lock bit", PGLK, 40, 1);
        do_program(40, 32'h1);
        do_reload(40);
        check_shadow("R8 locked program", 40);
        bus_read(STAT, d); check("R5 fail cleared", 32'(d[4]), 0);

        // R6 read lock
        shadow_write(3, 32'hDEAD_BEEF);
        check_shadow("R7 unlocked write", 3);
        set_lock(RDLK, 3);
        do_reload(3);
        check_shadow("R6 reload zero", 3);
        bus_write(RDLK, 32'h0);
        check_bit("R10 lock not cleared by 0", RDLK, 3, 1);

        // R7 write lock on bank 2
        shadow_write(65, 32'h1234_5678);
        set_lock(WRLK, 65);
        shadow_write(65, 32'hFFFF_0000);
        check_shadow("R7 locked write ignored", 65);
        shadow_write(66, 32'h0BAD_F00D);
        check_shadow("R7 neighbour write", 66);

        // Random mix against the model
        for (int it = 0; it < 60; it++) begin
            int w = $urandom_range(0, NW - 1);
            int k = $urandom_range(0, 4);
            logic [31:0] v = $urandom;
            case (k)
                0: shadow_write(w, v);
                1: do_program(w, v);
                2: do_reload(w);
                3: do_program(w, v & 32'h0000_0F0F);
                default: begin
                    int lk = $urandom_range(0, 2);
                    set_lock(lk == 0 ? RDLK : (lk == 1 ? WRLK : PGLK), w);
                end
            endcase
            check_shadow("R3 R4 R6 R7 R8 random shadow", w);
        end

        // R2 power down, R9 program rejected
        power(1'b0);
        bus_write(WDAT, 32'hFFFF_FFFF);
        bus_write(CMD, 32'h100 | 32'd20);
        bus_read(STAT, d); check("R9 no busy after power down", 32'(d[3]), 0);
        check_bit("R9 error set program", ERR, 20, 1);
        power(1'b1);
        do_reload(20);
        check_shadow("R9 fuse unchanged", 20);

        // R8 global lock
        bus_write(GLK, 32'h10);
        bus_write(GLK, 32'h0);
        bus_read(GLK, d); check("R10 global lock sticky", d, 32'h10);
        glk_m = 1'b1;
        do_program(21, 32'h8000_0001);
        do_reload(21);
        check_shadow("R8 global lock", 21);

        // R12 debug flag
        bus_write(DBG, 32'h400);
        bus_read(DBG, d); check("R12 debug readback", d, 32'h400);
        check("R12 debug pin", 32'(dbg_sw_en), 1);
        bus_write(DBG, 32'h0);
        check("R12 debug pin cleared", 32'(dbg_sw_en), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule